// File: doc/BRIEF.md
# Nibble-Mapped Multi-Function Pointer Register

This block holds a wide pointer that a 4-bit processor reaches one nibble at a time. Six small sub-registers sit on a narrow bus. Each one covers four consecutive pointer bits, except the last, which carries only the top pointer bit. The pointer width is a build parameter and may be 18 or 21 bits. Fixed slices of the pointer go out on dedicated field outputs. Downstream units such as a phase-step loader, an envelope loader and two mode transfers take their operands from these slices.

The block also keeps a 24-bit serial-flash address register. The pointer carries this address in both directions, twelve bits at a time. Two load strobes copy the low twelve pointer bits into the upper or lower half of the flash address. Two read strobes copy either half of the flash address back into the low twelve pointer bits. The pointer bits above bit 11 are not touched by a read. The instruction decoder drives the strobes, and the serial engine uses the flash address. Both of those units lie outside this block.

Top module: `mfp_pointer_reg`

## Requirements
- R1: After reset, every pointer bit, every read-back nibble and all 24 flash-address bits are zero.
- R2: A nibble write to sub-register k (k = 0..4) sets pointer bits [4k+3:4k]. A write to sub-register 5 sets pointer bit 20 from data bit 0. A read of sub-register k returns those same bits, with the result visible the cycle after the write edge.
- R3: Sub-register 5 returns zero on read bits [3:1]. Selects 6 and 7 read as zero and ignore writes.
- R4: In an 18-bit build, pointer bits [20:18] do not exist. Writes to them are dropped, and they read back as zero.
- R5: The field outputs follow the pointer without delay. The step field is bits [11:0], the envelope field is bits [7:0], mode field A is bits [5:0] and mode field B is bits [13:8].
- R6: A load-high strobe copies pointer bits [11:0] into flash-address bits [23:12] and leaves bits [11:0] unchanged. With no load strobe, the flash address holds its value.
- R7: A load-low strobe copies pointer bits [11:0] into flash-address bits [11:0] and leaves bits [23:12] unchanged.
- R8: A read-high strobe copies flash-address bits [23:12] into pointer bits [11:0]. Pointer bits above 11 keep their value.
- R9: A read-low strobe copies flash-address bits [11:0] into pointer bits [11:0]. Pointer bits above 11 keep their value.
- R10: If any transfer strobe is present in the same cycle as a nibble write, the write is discarded completely.
- R11: If both read strobes arrive together, the read-high copy takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 3 | Sub-register select |
| cpu_we | input | 1 | Nibble write strobe |
| cpu_wdata | input | 4 | Nibble write data |
| cpu_rdata | output | 4 | Nibble read data for the selected sub-register |
| xfer_ld_hi | input | 1 | Copy pointer [11:0] to flash address [23:12] |
| xfer_ld_lo | input | 1 | Copy pointer [11:0] to flash address [11:0] |
| xfer_rd_hi | input | 1 | Copy flash address [23:12] to pointer [11:0] |
| xfer_rd_lo | input | 1 | Copy flash address [11:0] to pointer [11:0] |
| flash_addr | output | 24 | Staged serial-flash address |
| ptr_value | output | PTR_W | Whole pointer |
| fld_step | output | 12 | Phase-step field |
| fld_env | output | 8 | Envelope field |
| fld_mode_a | output | 6 | Mode transfer field A |
| fld_mode_b | output | 6 | Mode transfer field B |

## Verification
The bench builds two copies of the block, one with PTR_W = 21 and one with PTR_W = 18. The wide copy reaches bit 20 through sub-register 5. It also runs the whole load and read round trip of the flash address, plus the strobe collisions. The narrow copy is used to show that sub-register 4 keeps only two live bits and that sub-register 5 has no storage at all.

// File: rtl/mfp_pkg.sv
package mfp_pkg;
  localparam int NIB_W    = 4;
  localparam int NSUB     = 6;
  localparam int SEL_W    = 3;
  localparam int HALF_W   = 12;
  localparam int FLASH_AW = 2 * HALF_W;
  localparam int PAD_W    = NSUB * NIB_W;

  typedef struct packed {
    logic ld_hi;
    logic ld_lo;
    logic rd_hi;
    logic rd_lo;
  } xfer_t;
endpackage

// File: rtl/mfp_nibble_file.sv
module mfp_nibble_file
  import mfp_pkg::*;
#(
  parameter int PTR_W = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     cpu_sel,
  input  logic                 cpu_we,
  input  logic [NIB_W-1:0]     cpu_wdata,
  input  xfer_t                xfer,
  input  logic [HALF_W-1:0]    flash_hi,
  input  logic [HALF_W-1:0]    flash_lo,
  output logic [PTR_W-1:0]     ptr_q
);
  logic [PTR_W-1:0] wmask;
  logic [PTR_W-1:0] wval;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic             any_ld;
  logic             any_rd;

  assign any_ld = xfer.ld_hi | xfer.ld_lo;
  assign any_rd = xfer.rd_hi | xfer.rd_lo;

  for (genvar gi = 0; gi < PTR_W; gi++) begin : g_bit
    assign wmask[gi] = cpu_we && (cpu_sel == SEL_W'(gi / NIB_W));
    assign wval[gi]  = cpu_wdata[gi % NIB_W];
  end

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (xfer.rd_hi) begin
      ptr_d[HALF_W-1:0] = flash_hi;
      ptr_en            = 1'b1;
    end else if (xfer.rd_lo) begin
      ptr_d[HALF_W-1:0] = flash_lo;
      ptr_en            = 1'b1;
    end else if (!any_ld) begin
      ptr_d  = (ptr_q & ~wmask) | (wval & wmask);
      ptr_en = |wmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assert_wr_nibble0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_sel == '0 && !any_ld && !any_rd) |=> ptr_q[NIB_W-1:0] == $past(cpu_wdata));

  assert_rd_keeps_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_rd |=> $stable(ptr_q[PTR_W-1:HALF_W]));

  assert_rd_hi_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer.rd_hi |=> ptr_q[HALF_W-1:0] == $past(flash_hi));

  assert_ld_blocks_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ld && !any_rd) |=> $stable(ptr_q));
endmodule

// File: rtl/mfp_flash_stage.sv
module mfp_flash_stage
  import mfp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [HALF_W-1:0]     ptr_lo,
  input  logic                  ld_hi,
  input  logic                  ld_lo,
  output logic [FLASH_AW-1:0]   flash_q
);
  logic [FLASH_AW-1:0] flash_d;
  logic                flash_en;

  always_comb begin
    flash_d  = flash_q;
    flash_en = ld_hi | ld_lo;
    if (ld_hi) flash_d[FLASH_AW-1:HALF_W] = ptr_lo;
    if (ld_lo) flash_d[HALF_W-1:0]        = ptr_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flash_q <= '0;
    end else if (flash_en) begin
      flash_q <= flash_d;
    end
  end

  assert_ld_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> flash_q[FLASH_AW-1:HALF_W] == $past(ptr_lo));

  assert_ld_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> flash_q[HALF_W-1:0] == $past(ptr_lo));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_hi && !ld_lo) |=> $stable(flash_q));
endmodule

// File: rtl/mfp_read_mux.sv
module mfp_read_mux
  import mfp_pkg::*;
#(
  parameter int PTR_W = 21
) (
  input  logic [PTR_W-1:0]  ptr_q,
  input  logic [SEL_W-1:0]  cpu_sel,
  output logic [NIB_W-1:0]  cpu_rdata
);
  logic [PAD_W-1:0] padded;

  assign padded = PAD_W'(ptr_q);

  always_comb begin
    cpu_rdata = '0;
    for (int k = 0; k < NSUB; k++) begin
      if (cpu_sel == SEL_W'(k)) cpu_rdata = padded[k*NIB_W +: NIB_W];
    end
  end
endmodule

// File: rtl/mfp_pointer_reg.sv
module mfp_pointer_reg
  import mfp_pkg::*;
#(
  parameter int PTR_W = 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cpu_sel,
  input  logic                cpu_we,
  input  logic [3:0]          cpu_wdata,
  output logic [3:0]          cpu_rdata,
  input  logic                xfer_ld_hi,
  input  logic                xfer_ld_lo,
  input  logic                xfer_rd_hi,
  input  logic                xfer_rd_lo,
  output logic [23:0]         flash_addr,
  output logic [PTR_W-1:0]    ptr_value,
  output logic [11:0]         fld_step,
  output logic [7:0]          fld_env,
  output logic [5:0]          fld_mode_a,
  output logic [5:0]          fld_mode_b
);
  logic [1:0]          rst_sync_q;
  logic                rst_core_n;
  xfer_t               xfer;
  logic [PTR_W-1:0]    ptr_q;
  logic [FLASH_AW-1:0] flash_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  assign xfer = '{ld_hi: xfer_ld_hi, ld_lo: xfer_ld_lo,
                  rd_hi: xfer_rd_hi, rd_lo: xfer_rd_lo};

  mfp_nibble_file #(.PTR_W(PTR_W)) u_file (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cpu_sel   (cpu_sel),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata),
    .xfer      (xfer),
    .flash_hi  (flash_q[FLASH_AW-1:HALF_W]),
    .flash_lo  (flash_q[HALF_W-1:0]),
    .ptr_q     (ptr_q)
  );

  mfp_flash_stage u_flash (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ptr_lo  (ptr_q[HALF_W-1:0]),
    .ld_hi   (xfer_ld_hi),
    .ld_lo   (xfer_ld_lo),
    .flash_q (flash_q)
  );

  mfp_read_mux #(.PTR_W(PTR_W)) u_rmux (
    .ptr_q     (ptr_q),
    .cpu_sel   (cpu_sel),
    .cpu_rdata (cpu_rdata)
  );

  assign flash_addr = flash_q;
  assign ptr_value  = ptr_q;
  assign fld_step   = ptr_q[11:0];
  assign fld_env    = ptr_q[7:0];
  assign fld_mode_a = ptr_q[5:0];
  assign fld_mode_b = ptr_q[13:8];

  assert_sub5_pad_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cpu_sel == 3'd5) |-> cpu_rdata[3:1] == 3'b000);

  assert_step_field_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    fld_step == ptr_value[11:0]);
endmodule

// File: tb/mfp_pointer_reg_bench.sv
module mfp_pointer_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cpu_sel = '0;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_wdata = '0;
  logic        ld_hi = 1'b0, ld_lo = 1'b0, rd_hi = 1'b0, rd_lo = 1'b0;
  logic [3:0]  cpu_rdata;
  logic [23:0] flash_addr;
  logic [20:0] ptr_value;
  logic [11:0] fld_step;
  logic [7:0]  fld_env;
  logic [5:0]  fld_mode_a, fld_mode_b;

  logic [2:0]  n_sel = '0;
  logic        n_we = 1'b0;
  logic [3:0]  n_wdata = '0;
  logic [3:0]  n_rdata;
  logic [23:0] n_flash;
  logic [17:0] n_ptr;
  logic [11:0] n_step;
  logic [7:0]  n_env;
  logic [5:0]  n_ma, n_mb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mfp_pointer_reg #(.PTR_W(21)) u_mfp_pointer_reg (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .xfer_ld_hi(ld_hi), .xfer_ld_lo(ld_lo), .xfer_rd_hi(rd_hi), .xfer_rd_lo(rd_lo),
    .flash_addr(flash_addr), .ptr_value(ptr_value), .fld_step(fld_step),
    .fld_env(fld_env), .fld_mode_a(fld_mode_a), .fld_mode_b(fld_mode_b)
  );

  mfp_pointer_reg #(.PTR_W(18)) u_mfp_pointer_reg_n18 (
    .clk(clk), .rst_n(rst_n), .cpu_sel(n_sel), .cpu_we(n_we),
    .cpu_wdata(n_wdata), .cpu_rdata(n_rdata),
    .xfer_ld_hi(1'b0), .xfer_ld_lo(1'b0), .xfer_rd_hi(1'b0), .xfer_rd_lo(1'b0),
    .flash_addr(n_flash), .ptr_value(n_ptr), .fld_step(n_step),
    .fld_env(n_env), .fld_mode_a(n_ma), .fld_mode_b(n_mb)
  );

  // entry: op[54:52] sel[51:49] data[48:45] exp_ptr[44:24] exp_flash[23:0]
  // op 0 write, 1 load-high, 2 load-low, 3 read-high, 4 read-low
  localparam int NV = 13;
  localparam logic [54:0] VEC [NV] = '{
    {3'd0, 3'd0, 4'h2, 21'h000002, 24'h000000},
    {3'd0, 3'd1, 4'h3, 21'h000032, 24'h000000},
    {3'd0, 3'd2, 4'h4, 21'h000432, 24'h000000},
    {3'd1, 3'd0, 4'h0, 21'h000432, 24'h432000},
    {3'd0, 3'd0, 4'hD, 21'h00043D, 24'h432000},
    {3'd0, 3'd3, 4'hA, 21'h00A43D, 24'h432000},
    {3'd0, 3'd4, 4'h7, 21'h07A43D, 24'h432000},
    {3'd0, 3'd5, 4'hF, 21'h17A43D, 24'h432000},
    {3'd2, 3'd0, 4'h0, 21'h17A43D, 24'h43243D},
    {3'd0, 3'd2, 4'h0, 21'h17A03D, 24'h43243D},
    {3'd3, 3'd0, 4'h0, 21'h17A432, 24'h43243D},
    {3'd4, 3'd0, 4'h0, 21'h17A43D, 24'h43243D},
    {3'd0, 3'd6, 4'h5, 21'h17A43D, 24'h43243D}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clear_inputs();
    cpu_we = 1'b0; ld_hi = 1'b0; ld_lo = 1'b0; rd_hi = 1'b0; rd_lo = 1'b0;
    n_we = 1'b0;
  endtask

  task automatic read_sel(input logic [2:0] s, input string req, input logic [3:0] exp);
    @(negedge clk);
    cpu_sel = s;
    #1;
    check(req, {28'd0, cpu_rdata}, {28'd0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    logic [54:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ptr", {11'd0, ptr_value}, 32'h0);
    check("R1 flash", {8'd0, flash_addr}, 32'h0);
    for (int s = 0; s < 6; s++) read_sel(3'(s), "R1 rdata", 4'h0);

    // vector walk: R2 R6 R7 R8 R9 R3
    for (int i = 0; i < NV; i++) begin
      e = VEC[i];
      @(negedge clk);
      cpu_sel = e[51:49];
      cpu_wdata = e[48:45];
      case (e[54:52])
        3'd0: cpu_we = 1'b1;
        3'd1: ld_hi = 1'b1;
        3'd2: ld_lo = 1'b1;
        3'd3: rd_hi = 1'b1;
        default: rd_lo = 1'b1;
      endcase
      @(negedge clk);
      clear_inputs();
      check($sformatf("R2/R3/R6-R9 vec%0d ptr", i), {11'd0, ptr_value}, {11'd0, e[44:24]});
      check($sformatf("R6/R7 vec%0d flash", i), {8'd0, flash_addr}, {8'd0, e[23:0]});
    end

    // R2 readback per sub-register, R3 sub-register 5 and select 7
    read_sel(3'd0, "R2 sel0", 4'hD);
    read_sel(3'd1, "R2 sel1", 4'h3);
    read_sel(3'd2, "R2 sel2", 4'h4);
    read_sel(3'd3, "R2 sel3", 4'hA);
    read_sel(3'd4, "R2 sel4", 4'h7);
    read_sel(3'd5, "R3 sel5", 4'h1);
    read_sel(3'd7, "R3 sel7", 4'h0);

    // R5 field outputs for pointer 0x17A43D
    check("R5 step", {20'd0, fld_step}, 32'h43D);
    check("R5 env", {24'd0, fld_env}, 32'h3D);
    check("R5 mode_a", {26'd0, fld_mode_a}, 32'h3D);
    check("R5 mode_b", {26'd0, fld_mode_b}, 32'h24);

    // R10 write with load-high: write lost, flash high gets 0x43D
    @(negedge clk);
    cpu_sel = 3'd0; cpu_wdata = 4'h1; cpu_we = 1'b1; ld_hi = 1'b1;
    @(negedge clk); clear_inputs();
    check("R10 ld ptr", {11'd0, ptr_value}, 32'h17A43D);
    check("R10 ld flash", {8'd0, flash_addr}, 32'h43D43D);

    // R10 write with read-high: sel3 nibble kept
    @(negedge clk);
    cpu_sel = 3'd3; cpu_wdata = 4'h0; cpu_we = 1'b1; rd_hi = 1'b1;
    @(negedge clk); clear_inputs();
    check("R10 rd ptr", {11'd0, ptr_value}, 32'h17A43D);

    // R11 set up differing halves, then both reads together
    @(negedge clk);
    cpu_sel = 3'd0; cpu_wdata = 4'h0; cpu_we = 1'b1;
    @(negedge clk); clear_inputs(); ld_lo = 1'b1;
    @(negedge clk); clear_inputs();
    check("R7 flash lo", {8'd0, flash_addr}, 32'h43D430);
    rd_hi = 1'b1; rd_lo = 1'b1;
    @(negedge clk); clear_inputs();
    check("R11 both reads", {11'd0, ptr_value}, 32'h17A43D);

    // R4 18-bit build
    n_sel = 3'd4; n_wdata = 4'hF; n_we = 1'b1;
    @(negedge clk); clear_inputs();
    check("R4 n18 ptr", {14'd0, n_ptr}, 32'h30000);
    #1 check("R4 n18 sel4", {28'd0, n_rdata}, 32'h3);
    @(negedge clk);
    n_sel = 3'd5; n_wdata = 4'hF; n_we = 1'b1;
    @(negedge clk); clear_inputs();
    check("R4 n18 ptr after sel5", {14'd0, n_ptr}, 32'h30000);
    #1 check("R4 n18 sel5", {28'd0, n_rdata}, 32'h0);

    // R1 reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset ptr", {11'd0, ptr_value}, 32'h0);
    check("R1 re-reset flash", {8'd0, flash_addr}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule